// File: doc/BRIEF.md
# ADC Result Queue with Byte-Serial Readout

This block sits between a converter core and a host serial port. Each 12-bit conversion result arrives with a one-cycle valid strobe and is stored in a small circular queue in arrival order. The host reads results back over a three-wire, SPI-style link. It drives an active-low select and a serial clock, and it receives one byte on the serial output during each select frame.

Every result is split into two bytes. The upper byte carries four zero bits and then bits 11..8 of the result. The lower byte carries bits 7..0. The upper byte is always sent first, and bits go out MSB first. A result is removed from the queue only after its lower byte has been fully clocked out. When the queue is full, a new result does not stall the converter. It replaces the oldest stored result.

The select and serial clock pins are oversampled by the system clock through a two-stage synchroniser. All queue and byte-phase updates happen in the system clock domain. The output bit moves on falling serial-clock edges, so the host samples it on rising edges.

Top module: `adcq_serial_out`

## Requirements
- R1: After reset the queue is empty, the byte phase points at an upper byte, and `sdo_o` is 0.
- R2: For a stored result D, the upper byte is {4'b0000, D[11:8]} and the lower byte is D[7:0]. The upper byte goes out first, and bits within a byte go out MSB first.
- R3: A frame that completes eight rising serial-clock edges consumes exactly one byte. A frame that completes the upper byte and then ends makes the next frame deliver the lower byte of the same result. The result leaves the queue only when its lower byte completes.
- R4: A frame that ends before eight rising serial-clock edges consumes nothing. The next frame repeats the same byte.
- R5: A frame that starts while the queue is empty shifts out eight zero bits and changes no queue state.
- R6: The queue holds up to DEPTH results and returns them in arrival order.
- R7: A result written while the queue holds DEPTH results (and no pop happens in that cycle) discards the oldest result. It also returns the byte phase to an upper byte, so the next frame delivers the upper byte of the oldest surviving result.
- R8: A write and a pop in the same cycle both take effect, and the occupancy is unchanged.
- R9: While select stays low, `sdo_o` changes only after a falling edge of the serial clock or of select. It holds steady across rising serial-clock edges. While select is high, `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the queue and the oversampling logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_valid_i | input | 1 | One-cycle strobe marking a new conversion result |
| res_data_i | input | 12 | Conversion result written when the strobe is high |
| csn_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock from the host (idles low) |
| sdo_o | output | 1 | Serial data toward the host |

## Verification
The bench builds the block with DEPTH set to 4 instead of 16. This lets a few writes reach the full condition, and the overwrite rule, the phase reset on overwrite and in-order draining of a full queue are all exercised. The serial clock runs at one sixteenth of the system clock so that the synchroniser latency sits well inside each half period. One frame is lined up so that a write lands in the same cycle as the pop of a lower byte.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;
  localparam int PAD_W  = 2 * BYTE_W - RES_W;

  typedef enum logic {
    PH_UPPER = 1'b0,
    PH_LOWER = 1'b1
  } byte_phase_e;
endpackage

// File: rtl/adcq_sync.sv
module adcq_sync #(
  parameter int              N       = 2,
  parameter logic [N-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta_q;
  logic [N-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/adcq_store.sv
module adcq_store
  import adcq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [RES_W-1:0] wr_data_i,
  input  logic             pop_i,
  output logic [RES_W-1:0] head_o,
  output logic             empty_o,
  output logic             drop_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [RES_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0] rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             full;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (cnt_q == FULL_CNT);
    drop_o   = wr_en_i && full && !pop_i;
    wr_ptr_d = wr_en_i ? step(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = (pop_i || drop_o) ? step(rd_ptr_q) : rd_ptr_q;
    cnt_d    = cnt_q;
    if (wr_en_i && !pop_i && !full) cnt_d = cnt_q + 1'b1;
    else if (pop_i && !wr_en_i)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en_i) mem_q[wr_ptr_q] <= wr_data_i;
  end

  assign head_o  = mem_q[rd_ptr_q];
  assign empty_o = (cnt_q == '0);

  a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);
  a_r7_full_write_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en_i) |=> (cnt_q == FULL_CNT));
  a_r8_count_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && pop_i) |=> (cnt_q == $past(cnt_q)));
  a_r5_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/adcq_shift.sv
module adcq_shift
  import adcq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csn_s_i,
  input  logic             sclk_s_i,
  input  logic             empty_i,
  input  logic [RES_W-1:0] head_i,
  input  logic             drop_i,
  output logic             pop_o,
  output logic             sdo_o
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W - 1);

  logic              csn_q, sclk_q;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic [3:0]        bit_q, bit_d;
  logic              live_q, live_d;
  byte_phase_e       ph_q, ph_d;
  logic              cs_fall, sclk_rise, sclk_fall, byte_done;

  always_comb begin
    cs_fall   = csn_q && !csn_s_i;
    sclk_rise = !csn_s_i && !sclk_q && sclk_s_i;
    sclk_fall = !csn_s_i && sclk_q && !sclk_s_i;
    byte_done = sclk_rise && live_q && (bit_q == LAST_BIT);
    pop_o     = byte_done && (ph_q == PH_LOWER);

    sh_d   = sh_q;
    bit_d  = bit_q;
    live_d = live_q;
    ph_d   = ph_q;

    if (csn_s_i) begin
      sh_d   = '0;
      live_d = 1'b0;
    end else if (cs_fall) begin
      bit_d  = '0;
      live_d = !empty_i;
      if (empty_i)               sh_d = '0;
      else if (ph_q == PH_UPPER) sh_d = {{PAD_W{1'b0}}, head_i[RES_W-1:BYTE_W]};
      else                       sh_d = head_i[BYTE_W-1:0];
    end else begin
      if (sclk_rise && bit_q <= LAST_BIT) bit_d = bit_q + 1'b1;
      if (sclk_fall) sh_d = {sh_q[BYTE_W-2:0], 1'b0};
      if (byte_done) begin
        live_d = 1'b0;
        ph_d   = (ph_q == PH_UPPER) ? PH_LOWER : PH_UPPER;
      end
    end

    if (drop_i) ph_d = PH_UPPER;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csn_q  <= 1'b1;
      sclk_q <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      live_q <= 1'b0;
      ph_q   <= PH_UPPER;
    end else begin
      csn_q  <= csn_s_i;
      sclk_q <= sclk_s_i;
      sh_q   <= sh_d;
      bit_q  <= bit_d;
      live_q <= live_d;
      ph_q   <= ph_d;
    end
  end

  assign sdo_o = sh_q[BYTE_W-1];

  a_r9_sdo_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn_s_i && !cs_fall && !sclk_fall) |=> $stable(sdo_o));
  a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s_i |=> !sdo_o);
  a_r3_upper_after_pop: assert property (@(posedge clk) disable iff (!rst_n)
    pop_o |=> (ph_q == PH_UPPER));
  a_r7_drop_restarts_phase: assert property (@(posedge clk) disable iff (!rst_n)
    drop_i |=> (ph_q == PH_UPPER));
endmodule

// File: rtl/adcq_serial_out.sv
module adcq_serial_out
  import adcq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             res_valid_i,
  input  logic [RES_W-1:0] res_data_i,
  input  logic             csn_i,
  input  logic             sclk_i,
  output logic             sdo_o
);
  logic [1:0]       pins_s;
  logic [RES_W-1:0] head;
  logic             empty, drop, pop;

  adcq_sync #(.N(2), .RST_VAL(2'b10)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   ({csn_i, sclk_i}),
    .q_o   (pins_s)
  );

  adcq_store #(.DEPTH(DEPTH)) i_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (res_valid_i),
    .wr_data_i (res_data_i),
    .pop_i     (pop),
    .head_o    (head),
    .empty_o   (empty),
    .drop_o    (drop)
  );

  adcq_shift i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_s_i  (pins_s[1]),
    .sclk_s_i (pins_s[0]),
    .empty_i  (empty),
    .head_i   (head),
    .drop_i   (drop),
    .pop_o    (pop),
    .sdo_o    (sdo_o)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !sdo_o);
endmodule

// File: tb/test_adcq_serial_out.sv
module test_adcq_serial_out;
  localparam int CLK_T = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid_i = 1'b0;
  logic [11:0] res_data_i = '0;
  logic        csn_i = 1'b1;
  logic        sclk_i = 1'b0;
  logic        sdo_o;

  int checks = 0;
  int errors = 0;

  logic [11:0] model_q[$];
  bit          model_lower = 1'b0;
  logic [7:0]  exp_q[$];
  logic [7:0]  act_q[$];
  string       tag_q[$];
  event        byte_done;
  bit          finished = 1'b0;

  adcq_serial_out #(.DEPTH(DEPTH)) i_adcq_serial_out (
    .clk(clk), .rst_n(rst_n), .res_valid_i(res_valid_i), .res_data_i(res_data_i),
    .csn_i(csn_i), .sclk_i(sclk_i), .sdo_o(sdo_o)
  );

  always #(CLK_T/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: pops expected bytes as captured bytes arrive
  initial begin
    forever begin
      @(byte_done);
      while (act_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a === e, t, a, e);
      end
    end
  end

  // Driver: one result, with the overwrite rule mirrored in the model (R7)
  task automatic push_res(input logic [11:0] d);
    res_valid_i = 1'b1;
    res_data_i  = d;
    if (model_q.size() == DEPTH) begin
      void'(model_q.pop_front());
      model_lower = 1'b0;
    end
    model_q.push_back(d);
    @(negedge clk);
    res_valid_i = 1'b0;
  endtask

  function automatic logic [7:0] model_byte();
    if (model_q.size() == 0) return 8'h00;
    return model_lower ? model_q[0][7:0] : {4'b0000, model_q[0][11:8]};
  endfunction

  task automatic frame(input int nbits, input string tag);
    logic [7:0] b = '0;
    logic [7:0] e;
    bit steady = 1'b1;
    e = model_byte();
    if (nbits == 8 && model_q.size() > 0) begin
      if (model_lower) void'(model_q.pop_front());
      model_lower = !model_lower;
    end
    csn_i = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      b = {b[6:0], sdo_o};
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
      if (sdo_o !== b[0]) steady = 1'b0;
      repeat (4) @(negedge clk);
      sclk_i = 1'b0;
      repeat (8) @(negedge clk);
    end
    csn_i = 1'b1;
    repeat (8) @(negedge clk);
    check(sdo_o === 1'b0, "R9 idle low", sdo_o, 0);
    check(steady, "R9 stable across rising edge", steady, 1);
    if (nbits == 8) begin
      exp_q.push_back(e);
      act_q.push_back(b);
      tag_q.push_back(tag);
      ->byte_done;
      @(negedge clk);
    end
  endtask

  initial begin
    #(CLK_T * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sdo_o === 1'b0, "R1 reset output", sdo_o, 0);
    frame(8, "R1 R5 empty after reset");

    // R2 / R3: byte format and ordering
    push_res(12'hABC);
    frame(8, "R2 upper byte");
    frame(8, "R3 lower byte");
    frame(8, "R5 empty after drain");

    // R4: aborted frame repeats the byte
    push_res(12'h5A3);
    push_res(12'h1F0);
    frame(3, "R4 partial");
    frame(8, "R4 repeated upper");
    frame(5, "R4 partial lower");
    frame(8, "R4 repeated lower");
    frame(8, "R2 second upper");
    frame(8, "R2 second lower");
    frame(8, "R5 empty again");

    // R6: fill to capacity and drain in order
    for (int k = 0; k < DEPTH; k++) push_res(12'(12'h111 * (k + 1)));
    for (int k = 0; k < 2 * DEPTH; k++) frame(8, "R6 in-order drain");
    frame(8, "R5 empty after full drain");

    // R7: overwrite oldest when full
    for (int k = 0; k < DEPTH + 2; k++) push_res(12'(12'h0A0 + k));
    frame(8, "R7 oldest survivor upper");
    push_res(12'h7E7);
    frame(8, "R7 phase restarts at upper");
    for (int k = 0; k < 2 * DEPTH; k++) frame(8, "R7 drain");
    frame(8, "R5 empty after overwrite drain");

    // R8: write lands in the cycle of the lower-byte pop
    push_res(12'h3C5);
    frame(8, "R8 upper");
    fork
      frame(8, "R8 lower with write");
      begin
        repeat (122) @(negedge clk);
        push_res(12'hD2E);
      end
    join
    frame(8, "R8 written upper");
    frame(8, "R8 written lower");
    frame(8, "R8 empty afterwards");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule